// File: doc/BRIEF.md
# Contig Edge Overlap Extender

This block follows a growing contig while keeping only its two ends. It holds a left window and a right window, and each window is exactly one read long. Every read that comes in is tested against both ends. The read is slid across each edge one base position per clock. At every shift offset the block checks whether the read and the edge agree over the bases where they overlap. When an overlap is found, the contig grows at that edge by the number of bases that extend past it. The interior of the contig is never touched and is never stored.

The caller loads a seed read with the first-read flag set, and that read becomes both windows. After that, each read is presented with a valid strobe. While the shift scan runs, the block raises busy. Each read produces exactly one result pulse. The pulse says whether the right edge grew, the left edge grew, or neither, and gives the number of bases added. When an edge grows, the new window at that edge is exactly the incoming read. This holds because the read covers the last (or first) read-length bases of the extended contig.

Top module: `edge_extender`

## Requirements
- R1: A read is READ_LEN bases at two bits each, with base i at bits [2i+1:2i]. The codes are A=00, C=01, T=10 and G=11.
- R2: A read accepted with rd_first high is copied into both windows. On the next cycle res_valid is high, both extension flags are low, res_len is 0, and busy stays low.
- R3: A read is accepted only when rd_valid is high and busy is low. A read without rd_first raises busy for exactly READ_LEN-MIN_OVL cycles. Reads offered while busy is high have no effect on the result or on the windows.
- R4: Right extension at shift s (1 ≤ s ≤ READ_LEN-MIN_OVL) needs two things. The read's first READ_LEN-s bases must equal the right window's last READ_LEN-s bases. The extension then sets res_right, replaces the right window with the read, and reports res_len = s.
- R5: Left extension at shift s needs the read's last READ_LEN-s bases to equal the left window's first READ_LEN-s bases. The extension then sets res_left, replaces the left window with the read, and reports res_len = s.
- R6: When both edges can be extended, the right edge is used and the left window is left unchanged.
- R7: An overlap of exactly MIN_OVL bases extends. An overlap of MIN_OVL-1 bases does not.
- R8: A read that matches neither edge gives a result with both flags low and res_len 0, and neither window changes.
- R9: During reset both windows are zero, and busy and res_valid are low.
- R10: When several shifts match at one edge, the smallest shift is used, which is the longest overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid | input | 1 | Read offered |
| rd_first | input | 1 | Read seeds a new contig |
| rd_bases | input | 2*READ_LEN | Read bases, base 0 in the low bits |
| busy | output | 1 | Shift scan in progress; reads are not accepted |
| res_valid | output | 1 | One-cycle result strobe |
| res_right | output | 1 | Right edge was extended |
| res_left | output | 1 | Left edge was extended |
| res_len | output | $clog2(READ_LEN+1) | Bases added to the contig |
| left_win | output | 2*READ_LEN | First READ_LEN bases of the contig |
| right_win | output | 2*READ_LEN | Last READ_LEN bases of the contig |

## Verification
The hardest case to reach from the ports is a read that overlaps both edges at once. That needs the two windows to differ, while each still overlaps the same read at a legal shift. The stimulus seeds a period-four pattern and then right-extends it with a read that ends in a run of T. This leaves the two windows different. A third read is then built by hand to overlap the right window and the left window at shift 8 each. Reads taken from a hashed pseudo-genome exercise both edges, including shifts of exactly MIN_OVL overlap and one base short of it.

// File: rtl/edge_ext_pkg.sv
package edge_ext_pkg;
  localparam int BASE_W = 2;
  typedef enum logic {ST_IDLE = 1'b0, ST_SCAN = 1'b1} scan_st_t;
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import edge_ext_pkg::*;
#(
  parameter int MAX_SHIFT = 80,
  parameter int CNT_W     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             last,
  output logic [CNT_W-1:0] cur_shift
);
  scan_st_t         st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    if (st_q == ST_IDLE) begin
      if (start) begin
        st_n  = ST_SCAN;
        cnt_n = CNT_W'(1);
      end
    end else begin
      if (cnt_q == CNT_W'(MAX_SHIFT)) st_n = ST_IDLE;
      else                            cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end

  assign busy      = (st_q == ST_SCAN);
  assign last      = busy && (cnt_q == CNT_W'(MAX_SHIFT));
  assign cur_shift = cnt_q;
endmodule

// File: rtl/edge_scan.sv
module edge_scan
  import edge_ext_pkg::*;
#(
  parameter int W     = 200,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [W-1:0]     slide_in,
  input  logic [W-1:0]     fixed_in,
  input  logic [CNT_W-1:0] cur_shift,
  output logic             found_nxt,
  output logic [CNT_W-1:0] shift_nxt
);
  logic [W-1:0]     slide_q, slide_n;
  logic [W-1:0]     fixed_q, fixed_n;
  logic [W-1:0]     mask_q, mask_n;
  logic             found_q, found_n;
  logic [CNT_W-1:0] shift_q, shift_n;
  logic             match;

  assign match     = (((slide_q ^ fixed_q) & mask_q) == '0);
  assign found_nxt = found_q | match;
  assign shift_nxt = found_q ? shift_q : cur_shift;

  always_comb begin
    slide_n = slide_q;
    fixed_n = fixed_q;
    mask_n  = mask_q;
    found_n = found_q;
    shift_n = shift_q;
    if (load) begin
      slide_n = slide_in >> BASE_W;
      fixed_n = fixed_in;
      mask_n  = {W{1'b1}} >> BASE_W;
      found_n = 1'b0;
      shift_n = '0;
    end else if (step) begin
      slide_n = slide_q >> BASE_W;
      mask_n  = mask_q >> BASE_W;
      found_n = found_nxt;
      shift_n = shift_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slide_q <= '0;
      fixed_q <= '0;
      mask_q  <= '0;
      found_q <= 1'b0;
      shift_q <= '0;
    end else begin
      slide_q <= slide_n;
      fixed_q <= fixed_n;
      mask_q  <= mask_n;
      found_q <= found_n;
      shift_q <= shift_n;
    end
  end
endmodule

// File: rtl/edge_extender.sv
module edge_extender
  import edge_ext_pkg::*;
#(
  parameter int READ_LEN = 100,
  parameter int MIN_OVL  = 20,
  localparam int W         = BASE_W * READ_LEN,
  localparam int LEN_W     = $clog2(READ_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_valid,
  input  logic             rd_first,
  input  logic [W-1:0]     rd_bases,
  output logic             busy,
  output logic             res_valid,
  output logic             res_right,
  output logic             res_left,
  output logic [LEN_W-1:0] res_len,
  output logic [W-1:0]     left_win,
  output logic [W-1:0]     right_win
);
  localparam int MAX_SHIFT = READ_LEN - MIN_OVL;

  logic accept, start, load_first, last;
  logic [LEN_W-1:0] cur_shift;
  logic             hit_found [2];
  logic [LEN_W-1:0] hit_shift [2];

  logic [W-1:0]     lw_q, lw_n, rw_q, rw_n, hold_q, hold_n;
  logic             rv_q, rv_n, rr_q, rr_n, rl_q, rl_n;
  logic [LEN_W-1:0] len_q, len_n;

  assign accept     = rd_valid && !busy;
  assign start      = accept && !rd_first;
  assign load_first = accept && rd_first;

  scan_ctrl #(.MAX_SHIFT(MAX_SHIFT), .CNT_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .last(last), .cur_shift(cur_shift)
  );

  // edge 0: right window slides under the read; edge 1: read slides under left window
  for (genvar g = 0; g < 2; g++) begin : g_edge
    logic [W-1:0] slide_src, fixed_src;
    if (g == 0) begin : g_right
      assign slide_src = rw_q;
      assign fixed_src = rd_bases;
    end else begin : g_left
      assign slide_src = rd_bases;
      assign fixed_src = lw_q;
    end
    edge_scan #(.W(W), .CNT_W(LEN_W)) u_scan (
      .clk(clk), .rst_n(rst_n), .load(start), .step(busy),
      .slide_in(slide_src), .fixed_in(fixed_src), .cur_shift(cur_shift),
      .found_nxt(hit_found[g]), .shift_nxt(hit_shift[g])
    );
  end

  always_comb begin
    lw_n   = lw_q;
    rw_n   = rw_q;
    hold_n = hold_q;
    rv_n   = 1'b0;
    rr_n   = rr_q;
    rl_n   = rl_q;
    len_n  = len_q;
    if (start) hold_n = rd_bases;
    if (load_first) begin
      lw_n  = rd_bases;
      rw_n  = rd_bases;
      rv_n  = 1'b1;
      rr_n  = 1'b0;
      rl_n  = 1'b0;
      len_n = '0;
    end else if (last) begin
      rv_n  = 1'b1;
      rr_n  = 1'b0;
      rl_n  = 1'b0;
      len_n = '0;
      if (hit_found[0]) begin
        rw_n  = hold_q;
        rr_n  = 1'b1;
        len_n = hit_shift[0];
      end else if (hit_found[1]) begin
        lw_n  = hold_q;
        rl_n  = 1'b1;
        len_n = hit_shift[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lw_q   <= '0;
      rw_q   <= '0;
      hold_q <= '0;
      rv_q   <= 1'b0;
      rr_q   <= 1'b0;
      rl_q   <= 1'b0;
      len_q  <= '0;
    end else begin
      lw_q   <= lw_n;
      rw_q   <= rw_n;
      hold_q <= hold_n;
      rv_q   <= rv_n;
      rr_q   <= rr_n;
      rl_q   <= rl_n;
      len_q  <= len_n;
    end
  end

  assign left_win  = lw_q;
  assign right_win = rw_q;
  assign res_valid = rv_q;
  assign res_right = rr_q;
  assign res_left  = rl_q;
  assign res_len   = len_q;
endmodule

// File: rtl/edge_extender_chk.sv
module edge_extender_chk #(
  parameter int READ_LEN = 100,
  parameter int MIN_OVL  = 20,
  localparam int W     = 2 * READ_LEN,
  localparam int LEN_W = $clog2(READ_LEN + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_valid,
  input logic             rd_first,
  input logic [W-1:0]     rd_bases,
  input logic             busy,
  input logic             res_valid,
  input logic             res_right,
  input logic             res_left,
  input logic [LEN_W-1:0] res_len,
  input logic [W-1:0]     left_win,
  input logic [W-1:0]     right_win
);
  localparam int MAX_SHIFT = READ_LEN - MIN_OVL;

  logic [W-1:0]  seen_q;
  logic [15:0]   run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      run_q  <= '0;
    end else begin
      if (rd_valid && !busy) seen_q <= rd_bases;
      run_q <= busy ? run_q + 16'd1 : 16'd0;
    end
  end

  a_r2_first_load: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !busy && rd_first |=> res_valid && !res_right && !res_left && !busy &&
      left_win == $past(rd_bases) && right_win == $past(rd_bases));

  a_r3_scan_start: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !busy && !rd_first |=> busy);

  a_r3_scan_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_q == 16'(MAX_SHIFT));

  a_r3_windows_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(left_win) && $stable(right_win));

  a_r4_right_update: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_right |-> right_win == seen_q && res_len >= 1 &&
      res_len <= LEN_W'(MAX_SHIFT));

  a_r5_left_update: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_left |-> left_win == seen_q && res_len >= 1 &&
      res_len <= LEN_W'(MAX_SHIFT));

  a_r6_one_edge: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot0({res_right, res_left}));

  a_r8_no_ext_len: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_right && !res_left |-> res_len == '0);
endmodule

bind edge_extender edge_extender_chk #(.READ_LEN(READ_LEN), .MIN_OVL(MIN_OVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_first(rd_first),
  .rd_bases(rd_bases), .busy(busy), .res_valid(res_valid), .res_right(res_right),
  .res_left(res_left), .res_len(res_len), .left_win(left_win), .right_win(right_win)
);

// File: tb/edge_extender_test.sv
`timescale 1ns/1ps
module edge_extender_test;
  localparam int RL  = 16;
  localparam int MO  = 8;
  localparam int W   = 2 * RL;
  localparam int LW  = $clog2(RL + 1);
  localparam int MXS = RL - MO;

  typedef struct packed {
    logic       first;
    logic [7:0] pos;
    logic [1:0] kind;   // 0 none, 1 right, 2 left
    logic [4:0] len;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b1, 8'd20, 2'd0, 5'd0},   // R2 seed, contig [20,36)
    '{1'b0, 8'd23, 2'd1, 5'd3},   // R4
    '{1'b0, 8'd17, 2'd2, 5'd3},   // R5
    '{1'b0, 8'd31, 2'd1, 5'd8},   // R7 overlap exactly MO on right
    '{1'b0, 8'd9,  2'd2, 5'd8},   // R7 overlap exactly MO on left
    '{1'b0, 8'd40, 2'd0, 5'd0},   // R7/R8 overlap MO-1 on right
    '{1'b0, 8'd0,  2'd0, 5'd0},   // R7/R8 overlap MO-1 on left
    '{1'b0, 8'd36, 2'd1, 5'd5}    // R4
  };

  logic clk, rst_n, rd_valid, rd_first;
  logic [W-1:0] rd_bases;
  logic busy, res_valid, res_right, res_left;
  logic [LW-1:0] res_len;
  logic [W-1:0] left_win, right_win;
  int n_checks, n_fail;

  edge_extender #(.READ_LEN(RL), .MIN_OVL(MO)) uut (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_first(rd_first),
    .rd_bases(rd_bases), .busy(busy), .res_valid(res_valid), .res_right(res_right),
    .res_left(res_left), .res_len(res_len), .left_win(left_win), .right_win(right_win)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [1:0] gbase(input int i);
    logic [31:0] h;
    h = 32'(i) * 32'h9E3779B1;
    h = h ^ (h >> 15);
    h = h * 32'h85EBCA77;
    h = h ^ (h >> 13);
    return h[17:16];
  endfunction

  function automatic logic [W-1:0] slice(input int p);
    logic [W-1:0] v;
    v = '0;
    for (int j = 0; j < RL; j++) v[2*j +: 2] = gbase(p + j);
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic first, input logic [W-1:0] bases);
    int t;
    rd_valid = 1'b1; rd_first = first; rd_bases = bases;
    @(negedge clk);
    rd_valid = 1'b0; rd_first = 1'b0;
    t = 0;
    while (!res_valid && t < 100) begin t++; @(negedge clk); end
    if (!res_valid) chk(1'b0, "result timeout", 32'(t), 32'd0);
  endtask

  task automatic chk_res(input string tag, input logic r, input logic l, input int len,
                         input logic [W-1:0] el, input logic [W-1:0] er);
    chk({res_right, res_left, 5'(res_len)} == {r, l, 5'(len)}, {tag, " flags/len"},
        32'({res_right, res_left, 5'(res_len)}), 32'({r, l, 5'(len)}));
    chk(left_win == el, {tag, " left_win"}, left_win, el);
    chk(right_win == er, {tag, " right_win"}, right_win, er);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int lo, hi, cnt;
    logic [W-1:0] wp, r1, q;
    n_checks = 0; n_fail = 0;
    rst_n = 1'b0; rd_valid = 1'b0; rd_first = 1'b0; rd_bases = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!busy && !res_valid && left_win == '0 && right_win == '0, "R9 reset state",
        {busy, res_valid, 30'd0}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: reads sliced from a hashed genome (R1 encoding in slice)
    lo = 0; hi = 0;
    for (int k = 0; k < 8; k++) begin
      send(VEC[k].first, slice(int'(VEC[k].pos)));
      if (VEC[k].first) begin
        lo = int'(VEC[k].pos); hi = lo + RL;
      end else if (VEC[k].kind == 2'd1) hi = int'(VEC[k].pos) + RL;
      else if (VEC[k].kind == 2'd2) lo = int'(VEC[k].pos);
      chk_res($sformatf("R4/R5/R7/R8 vector %0d", k), VEC[k].kind == 2'd1,
              VEC[k].kind == 2'd2, int'(VEC[k].len), slice(lo), slice(hi - RL));
    end

    // Directed, R1 encoding: ACGT repeated = 0xB4 per four bases
    wp = 32'hB4B4B4B4;
    r1 = 32'hAAB4B4B4;   // ACGT ACGT ACGT TTTT
    q  = 32'hB4B4AAB4;   // ACGT TTTT ACGT ACGT
    @(negedge clk);
    send(1'b1, wp);
    chk_res("R2 seed periodic", 1'b0, 1'b0, 0, wp, wp);

    // R3 stall and R10 longest overlap: period-4 read matches at 4 and 8
    rd_valid = 1'b1; rd_first = 1'b0; rd_bases = wp;
    @(negedge clk);
    rd_first = 1'b1; rd_bases = '0;   // ignored while busy
    cnt = 0;
    while (busy && cnt < 50) begin
      cnt++;
      if (cnt == 4) rd_valid = 1'b0;
      @(negedge clk);
    end
    rd_valid = 1'b0; rd_first = 1'b0;
    chk(cnt == MXS, "R3 busy length", 32'(cnt), 32'(MXS));
    chk(res_valid, "R3 result after scan", 32'(res_valid), 32'd1);
    chk_res("R3/R10 stall and shortest shift", 1'b1, 1'b0, 4, wp, wp);

    send(1'b0, r1);
    chk_res("R4 periodic right", 1'b1, 1'b0, 4, wp, r1);

    // R6: q overlaps right at shift 8 and left at shift 8
    send(1'b0, q);
    chk_res("R6 right priority", 1'b1, 1'b0, 8, wp, q);

    // R2 reseed then a busy-free idle check
    send(1'b1, r1);
    chk_res("R2 reseed", 1'b0, 1'b0, 0, r1, r1);
    chk(!busy, "R2 no busy on seed", 32'(busy), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule